// File: doc/BRIEF.md
# Isochronous IN Transmit FIFO with Control/Status Register

This block holds the outgoing bytes of one isochronous IN endpoint and exposes a single 8-bit control/status register to the processor. The processor pushes bytes into a FIFO that stores two maximum-size packets. Through the register it marks the final, shorter packet of a transfer, empties the FIFO, acknowledges completed packets and clears the underrun flag. It reads back whether the FIFO has room for another whole packet.

On the bus side a simplified engine asks for one packet per frame with a request pulse. The block chooses the packet length at that moment. If a full maximum-size packet is buffered, that packet is sent. If the short-packet mark is set, whatever is buffered is sent, even if that is nothing. Otherwise the request is an underrun and a zero-length packet is sent. The engine then pops the bytes one at a time and ends the packet with a done strobe.

Top module: `iso_tx_fifo_ctrl`

## Requirements
- R1: After reset the register reads 8'h01: the short-packet mark, underrun and complete flags are 0, the FIFO is empty and no packet is in progress.
- R2: Register bit positions: bit 7 short-packet mark, bit 3 underrun, bit 2 flush, bit 1 packet complete, bit 0 room-for-packet. Bits 6:4 and bit 2 always read 0.
- R3: The FIFO holds 2*PKT_MAX bytes. Bit 0 reads 1 exactly when the FIFO holds no more than PKT_MAX bytes.
- R4: A byte push while the FIFO holds 2*PKT_MAX bytes is dropped. The stored bytes and their order are unchanged.
- R5: Writing 1 to bit 7 sets the short-packet mark. Writing 0 leaves it unchanged.
- R6: Writing 1 to bit 2 discards every byte in the FIFO within the same cycle.
- R7: A request while at least PKT_MAX bytes are buffered starts a packet of length PKT_MAX whose bytes pop out in push order.
- R8: A request with fewer than PKT_MAX bytes buffered and the short-packet mark set starts a packet of exactly the buffered length, zero included, with no underrun. The mark clears when that packet's done strobe arrives.
- R9: A request with fewer than PKT_MAX bytes buffered and no short-packet mark sets the underrun flag and starts a zero-length packet. The FIFO is left untouched.
- R10: A done strobe during a packet sets the complete flag. Writing 1 to bit 1 clears it. A set in the same cycle as a clear wins.
- R11: Writing 1 to bit 3 clears the underrun flag. Writing 0 leaves it unchanged.
- R12: Pops beyond the packet length or outside a packet are ignored. A request during a packet is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | Push one byte into the FIFO |
| cpu_wr_data | input | DATA_W | Byte to push |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write value |
| csr_rdata | output | 8 | Register read value |
| usb_req | input | 1 | Request to start one packet |
| usb_pop | input | 1 | Consume the byte on usb_data |
| usb_done | input | 1 | Current packet finished |
| usb_active | output | 1 | A packet is in progress |
| usb_pkt_len | output | CNT_W | Length of the current packet |
| usb_data | output | DATA_W | Byte at the FIFO head |

## Verification
The bench builds the block with PKT_MAX = 8, so the FIFO is 16 bytes deep. With a FIFO that small, filling it to overflow, pointer wrap-around, the room flag's threshold at exactly 8 bytes and many packets per run all come within a short simulation. Random pushes, register writes and packet requests are mixed with directed cases: a zero-length short packet, a flush, and a complete-flag clear in the same cycle as a done strobe.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

  localparam int unsigned CSR_TSP = 7;
  localparam int unsigned CSR_TUR = 3;
  localparam int unsigned CSR_FTF = 2;
  localparam int unsigned CSR_TPC = 1;
  localparam int unsigned CSR_TFS = 0;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_FULL  = 2'd1,
    PK_SHORT = 2'd2,
    PK_ZERO  = 2'd3
  } pkt_kind_e;

  // room for one more whole packet in a FIFO of two packets
  function automatic logic has_room(input int unsigned occ, input int unsigned pmax);
    return occ <= pmax;
  endfunction

  // what a request sends given current occupancy and short mark
  function automatic pkt_kind_e classify(input int unsigned occ,
                                         input int unsigned pmax,
                                         input logic        short_mark);
    if (occ >= pmax)  return PK_FULL;
    else if (short_mark) return PK_SHORT;
    else return PK_ZERO;
  endfunction

endpackage

// File: rtl/iso_tx_fifo_store.sv
module iso_tx_fifo_store #(
  parameter int unsigned PKT_MAX = 256,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned DEPTH  = 2 * PKT_MAX,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     occ_o,
  output logic              push_evt_o,
  output logic              pop_evt_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     occ;

  assign push_evt_o = push_i && (occ != CW'(DEPTH)) && !flush_i;
  assign pop_evt_o  = pop_i && (occ != '0) && !flush_i;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_evt_o) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_evt_o) wr_ptr <= ptr_next(wr_ptr);
      if (pop_evt_o)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_evt_o, pop_evt_o})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign head_o = mem[rd_ptr];
  assign occ_o  = occ;

endmodule

// File: rtl/iso_tx_pkt_sched.sv
module iso_tx_pkt_sched
  import iso_tx_pkg::*;
#(
  parameter int unsigned PKT_MAX = 256,
  localparam int unsigned DEPTH  = 2 * PKT_MAX,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          pop_i,
  input  logic          done_i,
  input  logic          flush_i,
  input  logic [CW-1:0] occ_i,
  input  logic          tsp_i,
  output logic          active_o,
  output logic [CW-1:0] len_o,
  output logic          pop_o,
  output logic          underrun_evt_o,
  output logic          done_evt_o,
  output logic          short_done_evt_o
);

  logic          active, short_q;
  logic [CW-1:0] len_q, rem_q;
  logic          req_take;
  pkt_kind_e     kind;

  assign kind             = classify(32'(occ_i), PKT_MAX, tsp_i);
  assign req_take         = req_i && !active;
  assign underrun_evt_o   = req_take && (kind == PK_ZERO);
  assign done_evt_o       = done_i && active;
  assign short_done_evt_o = done_evt_o && short_q;
  assign pop_o            = pop_i && active && (rem_q != '0) && !flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      short_q <= 1'b0;
      len_q   <= '0;
      rem_q   <= '0;
    end else if (req_take) begin
      active  <= 1'b1;
      short_q <= (kind == PK_SHORT);
      case (kind)
        PK_FULL:  begin len_q <= CW'(PKT_MAX); rem_q <= CW'(PKT_MAX); end
        PK_SHORT: begin len_q <= occ_i;        rem_q <= occ_i;        end
        default:  begin len_q <= '0;           rem_q <= '0;           end
      endcase
    end else if (done_evt_o) begin
      active  <= 1'b0;
      short_q <= 1'b0;
      rem_q   <= '0;
    end else if (flush_i) begin
      rem_q <= '0;
    end else if (pop_o) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign active_o = active;
  assign len_o    = len_q;

endmodule

// File: rtl/iso_tx_csr.sv
module iso_tx_csr
  import iso_tx_pkg::*;
#(
  parameter int unsigned PKT_MAX = 256,
  localparam int unsigned DEPTH  = 2 * PKT_MAX,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic [CW-1:0] occ_i,
  input  logic          done_evt_i,
  input  logic          short_done_evt_i,
  input  logic          underrun_evt_i,
  output logic [7:0]    rdata_o,
  output logic          flush_o,
  output logic          tsp_o,
  output logic          tfs_o
);

  logic tsp_q, tur_q, tpc_q;
  logic unused_bits;

  assign unused_bits = ^{wdata_i[6:4], wdata_i[CSR_TFS]};
  assign flush_o     = wr_i && wdata_i[CSR_FTF];
  assign tfs_o       = has_room(32'(occ_i), PKT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsp_q <= 1'b0;
      tur_q <= 1'b0;
      tpc_q <= 1'b0;
    end else begin
      // setting events take precedence over clearing in one cycle
      if (wr_i && wdata_i[CSR_TSP])    tsp_q <= 1'b1;
      else if (short_done_evt_i)       tsp_q <= 1'b0;

      if (underrun_evt_i)              tur_q <= 1'b1;
      else if (wr_i && wdata_i[CSR_TUR]) tur_q <= 1'b0;

      if (done_evt_i)                  tpc_q <= 1'b1;
      else if (wr_i && wdata_i[CSR_TPC]) tpc_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[CSR_TSP] = tsp_q;
    rdata_o[CSR_TUR] = tur_q;
    rdata_o[CSR_TPC] = tpc_q;
    rdata_o[CSR_TFS] = tfs_o;
  end

  assign tsp_o = tsp_q;

endmodule

// File: rtl/iso_tx_fifo_ctrl.sv
module iso_tx_fifo_ctrl #(
  parameter int unsigned PKT_MAX = 256,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned DEPTH  = 2 * PKT_MAX,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              csr_wr_en,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              usb_req,
  input  logic              usb_pop,
  input  logic              usb_done,
  output logic              usb_active,
  output logic [CNT_W-1:0]  usb_pkt_len,
  output logic [DATA_W-1:0] usb_data
);

  logic [CNT_W-1:0] occ;
  logic flush_evt, push_evt, pop_evt, pop_gated;
  logic tsp, tfs;
  logic underrun_evt, done_evt, short_done_evt;

  iso_tx_fifo_store #(.PKT_MAX(PKT_MAX), .DATA_W(DATA_W)) store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (cpu_wr_en),
    .push_data_i (cpu_wr_data),
    .pop_i       (pop_gated),
    .flush_i     (flush_evt),
    .head_o      (usb_data),
    .occ_o       (occ),
    .push_evt_o  (push_evt),
    .pop_evt_o   (pop_evt)
  );

  iso_tx_pkt_sched #(.PKT_MAX(PKT_MAX)) sched_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_i            (usb_req),
    .pop_i            (usb_pop),
    .done_i           (usb_done),
    .flush_i          (flush_evt),
    .occ_i            (occ),
    .tsp_i            (tsp),
    .active_o         (usb_active),
    .len_o            (usb_pkt_len),
    .pop_o            (pop_gated),
    .underrun_evt_o   (underrun_evt),
    .done_evt_o       (done_evt),
    .short_done_evt_o (short_done_evt)
  );

  iso_tx_csr #(.PKT_MAX(PKT_MAX)) csr_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_i             (csr_wr_en),
    .wdata_i          (csr_wdata),
    .occ_i            (occ),
    .done_evt_i       (done_evt),
    .short_done_evt_i (short_done_evt),
    .underrun_evt_i   (underrun_evt),
    .rdata_o          (csr_rdata),
    .flush_o          (flush_evt),
    .tsp_o            (tsp),
    .tfs_o            (tfs)
  );

endmodule

// File: rtl/iso_tx_checker.sv
module iso_tx_checker #(
  parameter int unsigned PKT_MAX = 256,
  localparam int unsigned DEPTH  = 2 * PKT_MAX,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] occ,
  input logic          tfs,
  input logic          push_evt,
  input logic          pop_evt,
  input logic          flush_evt,
  input logic          underrun_evt,
  input logic          done_evt,
  input logic          short_done_evt,
  input logic          csr_wr_en,
  input logic [7:0]    csr_wdata,
  input logic [7:0]    csr_rdata,
  input logic          usb_active,
  input logic [CW-1:0] usb_pkt_len
);

  // R2: reserved and flush positions read as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[6:4] == 3'b000) && !csr_rdata[2]);

  // R3: room flag agrees with free space of at least one packet
  a_r3_room_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tfs == ((DEPTH - 32'(occ)) >= PKT_MAX));

  // R4: occupancy never exceeds capacity
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ) <= DEPTH);

  // R6: flush leaves the FIFO empty
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (occ == '0));

  // R8: short packet completion clears the mark unless rewritten
  a_r8_short_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (short_done_evt && !(csr_wr_en && csr_wdata[7])) |=> !csr_rdata[7]);

  // R9: underrun starts a zero-length packet and raises the flag
  a_r9_underrun_zlp: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> (usb_active && (usb_pkt_len == '0) && csr_rdata[3]));

  // R10: done sets the complete flag
  a_r10_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> csr_rdata[1]);

  // R12: an accepted pop removes exactly one byte
  a_r12_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt && !flush_evt) |=> (occ == $past(occ) - 1'b1));

endmodule

bind iso_tx_fifo_ctrl iso_tx_checker #(.PKT_MAX(PKT_MAX)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .occ            (occ),
  .tfs            (tfs),
  .push_evt       (push_evt),
  .pop_evt        (pop_evt),
  .flush_evt      (flush_evt),
  .underrun_evt   (underrun_evt),
  .done_evt       (done_evt),
  .short_done_evt (short_done_evt),
  .csr_wr_en      (csr_wr_en),
  .csr_wdata      (csr_wdata),
  .csr_rdata      (csr_rdata),
  .usb_active     (usb_active),
  .usb_pkt_len    (usb_pkt_len)
);

// File: tb/iso_tx_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
module iso_tx_fifo_ctrl_tb_top;

  localparam int P  = 8;
  localparam int CW = $clog2(2 * P + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr_en = 1'b0;
  logic [7:0]    cpu_wr_data = '0;
  logic          csr_wr_en = 1'b0;
  logic [7:0]    csr_wdata = '0;
  logic [7:0]    csr_rdata;
  logic          usb_req = 1'b0, usb_pop = 1'b0, usb_done = 1'b0;
  logic          usb_active;
  logic [CW-1:0] usb_pkt_len;
  logic [7:0]    usb_data;

  always #2.5 clk = ~clk;

  iso_tx_fifo_ctrl #(.PKT_MAX(P), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .usb_req(usb_req), .usb_pop(usb_pop), .usb_done(usb_done),
    .usb_active(usb_active), .usb_pkt_len(usb_pkt_len), .usb_data(usb_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] q[$];
  logic m_tsp = 0, m_tur = 0, m_tpc = 0;

  function automatic logic [7:0] exp_csr(int occ, logic tsp, logic tur, logic tpc);
    logic [7:0] v;
    v = 8'h00;
    if (tsp) v = v | 8'h80;
    if (tur) v = v | 8'h08;
    if (tpc) v = v | 8'h02;
    if (occ <= P) v = v | 8'h01;
    return v;
  endfunction

  // 0: zero-length underrun, 1: full, 2: short
  function automatic int exp_kind(int occ, logic tsp);
    if (occ >= P) return 1;
    if (tsp) return 2;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_csr(string req);
    check(req, csr_rdata, exp_csr(q.size(), m_tsp, m_tur, m_tpc));
  endtask

  task automatic push(logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    if (q.size() < 2 * P) q.push_back(d);
  endtask

  task automatic csr_write(logic [7:0] v);
    csr_wr_en = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_wr_en = 1'b0; csr_wdata = '0;
    if (v[7]) m_tsp = 1'b1;
    if (v[3]) m_tur = 1'b0;
    if (v[1]) m_tpc = 1'b0;
    if (v[2]) q.delete();
  endtask

  task automatic send(string req, bit clr_same);
    int k, len;
    k = exp_kind(q.size(), m_tsp);
    len = (k == 1) ? P : (k == 2) ? q.size() : 0;
    usb_req = 1'b1;
    @(negedge clk);
    usb_req = 1'b0;
    check(req, usb_active, 1);
    check(req, usb_pkt_len, len);
    // R12: second request while busy is ignored
    usb_req = 1'b1;
    @(negedge clk);
    usb_req = 1'b0;
    check("R12", usb_pkt_len, len);
    for (int i = 0; i < len; i++) begin
      check(req, usb_data, q[i]);
      usb_pop = 1'b1;
      @(negedge clk);
    end
    usb_pop = 1'b0;
    // R12: pop past the end of the packet is ignored
    usb_pop = 1'b1;
    @(negedge clk);
    usb_pop = 1'b0;
    if (q.size() > len) check("R12", usb_data, q[len]);
    usb_done = 1'b1;
    if (clr_same) begin csr_wr_en = 1'b1; csr_wdata = 8'h02; end
    @(negedge clk);
    usb_done = 1'b0; csr_wr_en = 1'b0; csr_wdata = '0;
    for (int i = 0; i < len; i++) void'(q.pop_front());
    if (k == 0) m_tur = 1'b1;
    if (k == 2) m_tsp = 1'b0;
    m_tpc = 1'b1;
    check(req, usb_active, 0);
    check_csr(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", csr_rdata, 8'h01);
    check("R1", usb_active, 0);

    // R3: threshold at exactly P bytes
    for (int i = 0; i < P; i++) push(8'(8'h10 + i));
    check("R3", csr_rdata[0], 1);
    push(8'h18);
    check("R3", csr_rdata[0], 0);
    // R4: fill and overflow
    for (int i = 0; i < P + 2; i++) push(8'(8'h20 + i));
    check("R4", q.size(), 2 * P);
    check_csr("R4");
    send("R7", 0);
    send("R7", 0);
    check_csr("R3");

    // R9: empty, no mark -> underrun zero-length packet
    send("R9", 0);
    check("R9", csr_rdata[3], 1);
    csr_write(8'h08);
    check("R11", csr_rdata[3], 0);
    csr_write(8'h02);
    check("R10", csr_rdata[1], 0);

    // R8: short packet
    push(8'hA1); push(8'hA2); push(8'hA3);
    csr_write(8'h80);
    check("R5", csr_rdata[7], 1);
    send("R8", 0);
    check("R8", csr_rdata[7], 0);
    // R8: mark with empty FIFO is a zero-length packet, no underrun
    csr_write(8'h80);
    send("R8", 0);
    check("R8", csr_rdata[3], 0);

    // R6: flush
    for (int i = 0; i < 5; i++) push(8'(8'h50 + i));
    csr_write(8'h04);
    check("R6", csr_rdata, exp_csr(0, m_tsp, m_tur, m_tpc));
    check("R2", csr_rdata[2], 0);
    send("R9", 0);

    // R10: clear in same cycle as done loses
    push(8'h61);
    csr_write(8'h88);
    send("R10", 1);
    check("R10", csr_rdata[1], 1);
    // R5/R11: writing zero changes nothing
    csr_write(8'h00);
    check_csr("R5");
    check("R2", csr_rdata[6:4], 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 8;
      if (op < 4) begin
        int n;
        n = 1 + $urandom % 6;
        for (int j = 0; j < n; j++) push(8'($urandom));
        check_csr("R3");
      end else if (op < 6) begin
        logic [7:0] w;
        w = 8'($urandom) & 8'h8A;
        if ($urandom % 6 == 0) w = w | 8'h04;
        csr_write(w);
        check_csr("R6");
      end else begin
        send("R7", ($urandom % 4) == 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule